// File: doc/BRIEF.md
# Dual receive buffer controller

This block takes the byte stream coming out of an Ethernet receiver (data, valid and an end-of-frame marker) and stores each frame in one of two receive banks. The first bank is always built. The second bank is built only when the `HAS_PONG` parameter is set. Every byte of the frame is stored, from the first destination address byte through the four trailing check bytes. Bytes are packed little-endian into 32-bit words, and software reads them back one word at a time.

Each bank has a status word with two bits. A done flag tells software that the bank holds a complete frame. An interrupt enable, when set, turns the rising edge of that done flag into a one-cycle interrupt pulse.

Banks are used in turn: the first bank after reset, then the other bank after every frame that completes. If the bank due next still holds an unread frame, the incoming frame is discarded and a drop counter is incremented. A frame larger than a bank keeps its first bytes, but it never marks the bank done. Software returns a bank to the block by writing a zero to that bank's done bit.

Top module: `dual_rx_bank_ctrl`

## Requirements
- R1: After reset, both status words read 0, `irq` is 0, `drop_count` is 0, and the first frame received goes to bank 0.
- R2: Byte k of a stored frame (k counted from 0) appears in word k/4, bits [8*(k mod 4)+7 : 8*(k mod 4)]. All received bytes are kept, including the final four. In the last word, the byte lanes past the end of the frame read 0.
- R3: Bit 0 of a bank's status word (done) reads 1 from the clock edge that samples the last byte of a frame stored in that bank.
- R4: A status write with data bit 0 at 0 clears that bank's done bit. A status write with bit 0 at 1 never sets it.
- R5: Bit 3 of a status word is the interrupt enable. Every status write to the bank loads it from data bit 3, and it reads back in the same position.
- R6: With both banks built, stored frames go to bank 0 and bank 1 alternately. The bank choice advances only when a frame has been stored completely.
- R7: If the bank due next has its done bit set when a frame begins, the whole frame is discarded. The bank's contents are left unchanged, the choice of next bank does not change, and `drop_count` goes up by one (it saturates at its maximum).
- R8: A frame longer than 4*`DEPTH_WORDS` bytes keeps its first 4*`DEPTH_WORDS` bytes. The bank is not marked done, and the next frame goes to the same bank.
- R9: `irq` is high for exactly one cycle, in the cycle in which a done bit first reads 1, and only if that bank's interrupt enable was set. Otherwise it stays low.
- R10: With `HAS_PONG`=0, every frame goes to bank 0, `pong_status` reads 0, and a read with `rd_sel`=1 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | rx_data is valid in this cycle |
| rx_last | input | 1 | Current byte ends the frame |
| sw_wr | input | 1 | Status write strobe |
| sw_sel | input | 1 | Bank addressed by the status write (0 or 1) |
| sw_wdata | input | 32 | Status write data (bit 0 done, bit 3 enable) |
| rd_sel | input | 1 | Bank being read |
| rd_addr | input | $clog2(DEPTH_WORDS) | Word index being read |
| rd_data | output | 32 | Word read from the selected bank (combinational) |
| ping_status | output | 32 | Bank 0 status word |
| pong_status | output | 32 | Bank 1 status word |
| irq | output | 1 | One-cycle frame-received pulse |
| drop_count | output | DROP_W | Saturating count of discarded frames |

## Verification
The done bit, the interrupt pulse and the next-bank choice all update on the same edge, the one that samples the last byte. The drop counter updates on the edge that samples a frame's first byte. A status write takes effect on the edge that samples the strobe. The bench drives every input on a falling edge and returns from each stimulus task on the falling edge just after the edge that consumed it. Status, `irq` and `drop_count` are checked at that point, and `irq` is checked again one falling edge later to confirm it has gone low. Stored words are read through the combinational read port while the stream is idle, so their values cannot change during the read.

// File: rtl/dual_rx_pkg.sv
package dual_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_FILL = 2'd1,
    RX_DROP = 2'd2
  } rx_state_e;

  localparam int STAT_DONE_BIT = 0;
  localparam int STAT_IE_BIT   = 3;

  // Build a 32-bit status word from the two live bits.
  function automatic logic [31:0] pack_status(input logic done, input logic ie);
    logic [31:0] s;
    s = '0;
    s[STAT_DONE_BIT] = done;
    s[STAT_IE_BIT]   = ie;
    return s;
  endfunction

endpackage

// File: rtl/rxb_sat_counter.sv
module rxb_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= '0;
    else if (inc && count != MAXV)
      count <= count + W'(1);
  end

endmodule

// File: rtl/rxb_bank.sv
module rxb_bank #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [1:0]    wr_lane,
  input  logic [7:0]    wr_byte,
  input  logic          set_done,
  input  logic          sw_wr,
  input  logic          sw_done_bit,
  input  logic          sw_ie_bit,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_word,
  output logic          done,
  output logic          ie
);

  logic [31:0] mem [DEPTH];

  // Lane 0 starts a new word and zeroes the lanes above it.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (wr_lane == 2'd0)
        mem[wr_addr] <= {24'd0, wr_byte};
      else
        mem[wr_addr][{wr_lane, 3'b000} +: 8] <= wr_byte;
    end
  end

  assign rd_word = mem[rd_addr];

  // Only the hardware sets done; only software clears it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0;
      ie   <= 1'b0;
    end else begin
      if (set_done)
        done <= 1'b1;
      else if (sw_wr && !sw_done_bit)
        done <= 1'b0;
      if (sw_wr)
        ie <= sw_ie_bit;
    end
  end

endmodule

// File: rtl/rxb_frame_ctrl.sv
module rxb_frame_ctrl
  import dual_rx_pkg::*;
#(
  parameter int NBANK     = 2,
  parameter int CAP_BYTES = 64,
  parameter int CNT_W     = 7,
  parameter int AW        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       rx_data,
  input  logic             rx_valid,
  input  logic             rx_last,
  input  logic [NBANK-1:0] bank_done,
  output logic             wr_en,
  output logic             wr_bank,
  output logic [AW-1:0]    wr_addr,
  output logic [1:0]       wr_lane,
  output logic [7:0]       wr_byte,
  output logic             store_evt,
  output logic             drop_evt
);

  function automatic logic [AW-1:0] word_of(input logic [CNT_W-1:0] c);
    return AW'(c >> 2);
  endfunction

  function automatic logic [1:0] lane_of(input logic [CNT_W-1:0] c);
    return c[1:0];
  endfunction

  function automatic logic has_room(input logic [CNT_W-1:0] c);
    return c < CNT_W'(CAP_BYTES);
  endfunction

  rx_state_e        state;
  logic             cur_bank, next_bank;
  logic [CNT_W-1:0] byte_cnt;
  logic             ovf;

  logic [1:0]       done_ext;
  logic             in_idle, tgt_bank, tgt_busy, fill_byte, room, ovf_now;
  logic [CNT_W-1:0] eff_cnt;

  generate
    if (NBANK == 2) begin : g_two
      assign done_ext = bank_done;
    end else begin : g_one
      assign done_ext = {1'b0, bank_done};
    end
  endgenerate

  assign in_idle   = (state == RX_IDLE);
  assign tgt_bank  = in_idle ? next_bank : cur_bank;
  assign tgt_busy  = done_ext[next_bank];
  assign eff_cnt   = in_idle ? '0 : byte_cnt;
  assign room      = has_room(eff_cnt);
  assign fill_byte = rx_valid && ((in_idle && !tgt_busy) || state == RX_FILL);
  assign ovf_now   = (!in_idle && ovf) || (fill_byte && !room);

  assign wr_en     = fill_byte && room;
  assign wr_bank   = tgt_bank;
  assign wr_addr   = word_of(eff_cnt);
  assign wr_lane   = lane_of(eff_cnt);
  assign wr_byte   = rx_data;
  assign store_evt = fill_byte && rx_last && !ovf_now;
  assign drop_evt  = rx_valid && in_idle && tgt_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      cur_bank  <= 1'b0;
      next_bank <= 1'b0;
      byte_cnt  <= '0;
      ovf       <= 1'b0;
    end else begin
      if (rx_valid) begin
        case (state)
          RX_IDLE: begin
            cur_bank <= next_bank;
            byte_cnt <= CNT_W'(1);
            ovf      <= 1'b0;
            if (!rx_last)
              state <= tgt_busy ? RX_DROP : RX_FILL;
          end
          RX_FILL: begin
            if (room)
              byte_cnt <= byte_cnt + CNT_W'(1);
            ovf <= ovf_now;
            if (rx_last)
              state <= RX_IDLE;
          end
          RX_DROP: begin
            if (rx_last)
              state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
      if (store_evt && NBANK == 2)
        next_bank <= ~tgt_bank;
    end
  end

endmodule

// File: rtl/dual_rx_bank_ctrl.sv
module dual_rx_bank_ctrl
  import dual_rx_pkg::*;
#(
  parameter int DEPTH_WORDS = 16,
  parameter bit HAS_PONG    = 1'b1,
  parameter int DROP_W      = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [7:0]                     rx_data,
  input  logic                           rx_valid,
  input  logic                           rx_last,
  input  logic                           sw_wr,
  input  logic                           sw_sel,
  input  logic [31:0]                    sw_wdata,
  input  logic                           rd_sel,
  input  logic [$clog2(DEPTH_WORDS)-1:0] rd_addr,
  output logic [31:0]                    rd_data,
  output logic [31:0]                    ping_status,
  output logic [31:0]                    pong_status,
  output logic                           irq,
  output logic [DROP_W-1:0]              drop_count
);

  localparam int NBANK     = HAS_PONG ? 2 : 1;
  localparam int CAP_BYTES = DEPTH_WORDS * 4;
  localparam int CNT_W     = $clog2(CAP_BYTES + 1);
  localparam int AW        = $clog2(DEPTH_WORDS);

  logic             wr_en, wr_bank, store_evt, drop_evt;
  logic [AW-1:0]    wr_addr;
  logic [1:0]       wr_lane;
  logic [7:0]       wr_byte;
  logic [NBANK-1:0] bank_done, bank_ie, set_vec;
  logic [31:0]      bank_word [NBANK];
  logic             unused_wdata;

  assign unused_wdata = ^{sw_wdata[31:4], sw_wdata[2:1]};

  rxb_frame_ctrl #(
    .NBANK(NBANK), .CAP_BYTES(CAP_BYTES), .CNT_W(CNT_W), .AW(AW)
  ) u_frame (
    .clk(clk), .rst_n(rst_n),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last),
    .bank_done(bank_done),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_lane(wr_lane), .wr_byte(wr_byte),
    .store_evt(store_evt), .drop_evt(drop_evt)
  );

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign set_vec[b] = store_evt && (wr_bank == 1'(b));
      rxb_bank #(.DEPTH(DEPTH_WORDS), .AW(AW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en && (wr_bank == 1'(b))),
        .wr_addr(wr_addr), .wr_lane(wr_lane), .wr_byte(wr_byte),
        .set_done(set_vec[b]),
        .sw_wr(sw_wr && (sw_sel == 1'(b))),
        .sw_done_bit(sw_wdata[STAT_DONE_BIT]),
        .sw_ie_bit(sw_wdata[STAT_IE_BIT]),
        .rd_addr(rd_addr), .rd_word(bank_word[b]),
        .done(bank_done[b]), .ie(bank_ie[b])
      );
    end

    if (HAS_PONG) begin : g_pong_out
      assign rd_data     = rd_sel ? bank_word[1] : bank_word[0];
      assign pong_status = pack_status(bank_done[1], bank_ie[1]);
    end else begin : g_ping_only
      assign rd_data     = rd_sel ? 32'd0 : bank_word[0];
      assign pong_status = '0;
    end
  endgenerate

  assign ping_status = pack_status(bank_done[0], bank_ie[0]);

  always_ff @(posedge clk) begin
    if (!rst_n)
      irq <= 1'b0;
    else
      irq <= |(set_vec & bank_ie);
  end

  rxb_sat_counter #(.W(DROP_W)) u_drops (
    .clk(clk), .rst_n(rst_n), .inc(drop_evt), .count(drop_count)
  );

endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
  parameter bit HAS_PONG = 1'b1,
  parameter int DROP_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_wr,
  input logic              sw_sel,
  input logic              sw_done_wbit,
  input logic [31:0]       ping_status,
  input logic [31:0]       pong_status,
  input logic              irq,
  input logic [DROP_W-1:0] drop_count,
  input logic              store_evt,
  input logic              wr_en,
  input logic              wr_bank,
  input logic              drop_evt
);

  // R3: a completed frame marks its bank done on the next edge
  assert_store_ping_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (store_evt && !wr_bank) |=> ping_status[0]);
  assert_store_pong_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (store_evt && wr_bank) |=> pong_status[0]);

  // R7: a bank holding an unread frame is never written
  assert_no_write_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !(wr_bank ? pong_status[0] : ping_status[0]));

  // R7: each discarded frame adds one to the counter until it saturates
  assert_drop_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && drop_count != '1) |=> drop_count == $past(drop_count) + DROP_W'(1));

  // R4: done falls only after a software write of zero to that bank
  assert_ping_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ping_status[0]) |-> $past(sw_wr && !sw_sel && !sw_done_wbit));
  assert_pong_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pong_status[0]) |-> $past(sw_wr && sw_sel && !sw_done_wbit));

  // R9: the interrupt pulse matches a rising done with its enable set
  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (($rose(ping_status[0]) && $past(ping_status[3])) ||
             ($rose(pong_status[0]) && $past(pong_status[3]))));

  generate
    if (!HAS_PONG) begin : g_np
      // R10: absent second bank always reads as zero
      assert_no_pong_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pong_status == 32'd0);
    end
  endgenerate

endmodule

bind dual_rx_bank_ctrl rxb_checker #(.HAS_PONG(HAS_PONG), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .sw_wr(sw_wr), .sw_sel(sw_sel), .sw_done_wbit(sw_wdata[0]),
  .ping_status(ping_status), .pong_status(pong_status),
  .irq(irq), .drop_count(drop_count),
  .store_evt(store_evt), .wr_en(wr_en), .wr_bank(wr_bank), .drop_evt(drop_evt)
);

// File: tb/dual_rx_bank_ctrl_tb.sv
`timescale 1ns/1ps
module dual_rx_bank_ctrl_tb;

  localparam int DEPTH = 16;
  localparam int CAP   = DEPTH * 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        tgt = 1'b0;  // 0: u_dut, 1: u_np
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic        sw_wr = 1'b0, sw_sel = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic        rd_sel = 1'b0;
  logic [3:0]  rd_addr = '0;

  logic [31:0] a_rd, a_ping, a_pong, b_rd, b_ping, b_pong;
  logic        a_irq, b_irq;
  logic [7:0]  a_drop, b_drop;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  dual_rx_bank_ctrl #(.DEPTH_WORDS(DEPTH), .HAS_PONG(1'b1), .DROP_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rx_data(rx_data), .rx_valid(rx_valid && !tgt), .rx_last(rx_last),
    .sw_wr(sw_wr && !tgt), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
    .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(a_rd),
    .ping_status(a_ping), .pong_status(a_pong), .irq(a_irq), .drop_count(a_drop)
  );

  dual_rx_bank_ctrl #(.DEPTH_WORDS(DEPTH), .HAS_PONG(1'b0), .DROP_W(8)) u_np (
    .clk(clk), .rst_n(rst_n),
    .rx_data(rx_data), .rx_valid(rx_valid && tgt), .rx_last(rx_last),
    .sw_wr(sw_wr && tgt), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
    .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(b_rd),
    .ping_status(b_ping), .pong_status(b_pong), .irq(b_irq), .drop_count(b_drop)
  );

  function automatic logic [7:0] fb(input int seed, input int k);
    return 8'((seed * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input int seed, input int len);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = fb(seed, k);
      rx_last  = (k == len - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_last  = 1'b0;
  endtask

  task automatic sw_write(input logic sel, input logic [31:0] data);
    @(negedge clk);
    sw_wr = 1'b1; sw_sel = sel; sw_wdata = data;
    @(negedge clk);
    sw_wr = 1'b0;
  endtask

  task automatic check_bank(input logic bank, input int seed, input int len,
                            input string tag);
    int n;
    n = (len > CAP) ? CAP : len;
    for (int w = 0; w < (n + 3) / 4; w++) begin
      logic [31:0] exp;
      logic [31:0] act;
      exp = '0;
      for (int l = 0; l < 4; l++)
        if (w * 4 + l < n) exp[8*l +: 8] = fb(seed, w * 4 + l);
      rd_sel = bank; rd_addr = 4'(w);
      #1;
      act = tgt ? b_rd : a_rd;
      chk(act == exp, tag, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(a_ping == 0, "R1 ping status", a_ping, 0);
    chk(a_pong == 0, "R1 pong status", a_pong, 0);
    chk(a_irq == 0, "R1 irq", 32'(a_irq), 0);
    chk(a_drop == 0, "R1 drop count", 32'(a_drop), 0);
  endtask

  task automatic t_first_frame();
    sw_write(1'b0, 32'h8);
    chk(a_ping == 32'h8, "R5 ie readback", a_ping, 32'h8);
    send(1, 10);
    chk(a_ping == 32'h9, "R1 R3 first frame to ping, done", a_ping, 32'h9);
    chk(a_pong == 0, "R6 pong untouched", a_pong, 0);
    chk(a_irq == 1, "R9 irq pulse", 32'(a_irq), 1);
    @(negedge clk);
    chk(a_irq == 0, "R9 irq one cycle", 32'(a_irq), 0);
    check_bank(1'b0, 1, 10, "R2 ping packing");
  endtask

  task automatic t_alternate();
    send(2, 7);
    chk(a_pong == 32'h1, "R6 second frame to pong", a_pong, 32'h1);
    chk(a_irq == 0, "R9 no irq without enable", 32'(a_irq), 0);
    check_bank(1'b1, 2, 7, "R2 pong packing");
  endtask

  task automatic t_drop();
    send(3, 12);
    chk(a_drop == 1, "R7 drop counted", 32'(a_drop), 1);
    chk(a_ping == 32'h9, "R7 ping status kept", a_ping, 32'h9);
    chk(a_pong == 32'h1, "R7 pong status kept", a_pong, 32'h1);
    chk(a_irq == 0, "R9 no irq on drop", 32'(a_irq), 0);
    check_bank(1'b0, 1, 10, "R7 ping contents kept");
  endtask

  task automatic t_clear();
    sw_write(1'b0, 32'h8);
    chk(a_ping == 32'h8, "R4 clear ping keeps ie", a_ping, 32'h8);
    sw_write(1'b1, 32'h1);
    chk(a_pong == 32'h1, "R4 write 1 keeps done", a_pong, 32'h1);
    sw_write(1'b1, 32'h0);
    chk(a_pong == 32'h0, "R4 clear pong", a_pong, 0);
    sw_write(1'b1, 32'h1);
    chk(a_pong == 32'h0, "R4 write 1 never sets", a_pong, 0);
  endtask

  task automatic t_pointer();
    send(4, 4);
    chk(a_ping == 32'h9, "R7 R6 drop kept pointer on ping", a_ping, 32'h9);
    chk(a_irq == 1, "R9 irq with enable", 32'(a_irq), 1);
    check_bank(1'b0, 4, 4, "R2 one full word");
    send(5, 1);
    chk(a_pong == 32'h1, "R6 single byte to pong", a_pong, 32'h1);
    check_bank(1'b1, 5, 1, "R2 single byte lanes zero");
  endtask

  task automatic t_trunc();
    sw_write(1'b0, 32'h0);
    sw_write(1'b1, 32'h0);
    send(6, CAP + 6);
    chk(a_ping == 0, "R8 oversize not done", a_ping, 0);
    chk(a_pong == 0, "R8 pong untouched", a_pong, 0);
    chk(a_irq == 0, "R8 no irq on oversize", 32'(a_irq), 0);
    check_bank(1'b0, 6, CAP + 6, "R8 first bytes kept");
    send(7, 9);
    chk(a_ping == 32'h1, "R8 next frame same bank", a_ping, 32'h1);
    chk(a_pong == 0, "R8 pong still free", a_pong, 0);
    check_bank(1'b0, 7, 9, "R8 R2 refill");
  endtask

  task automatic t_no_pong();
    tgt = 1'b1;
    send(8, 6);
    chk(b_ping == 32'h1, "R10 first frame to ping", b_ping, 32'h1);
    chk(b_pong == 0, "R10 pong reads 0", b_pong, 0);
    send(9, 5);
    chk(b_drop == 1, "R10 R7 drop when ping full", 32'(b_drop), 1);
    check_bank(1'b0, 8, 6, "R10 contents kept");
    sw_write(1'b0, 32'h0);
    send(10, 3);
    chk(b_ping == 32'h1, "R10 second stored frame to ping", b_ping, 32'h1);
    chk(b_pong == 0, "R10 pong still 0", b_pong, 0);
    check_bank(1'b0, 10, 3, "R10 packing");
    rd_sel = 1'b1; rd_addr = '0;
    #1;
    chk(b_rd == 0, "R10 absent bank reads 0", b_rd, 0);
    tgt = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_frame();
    t_alternate();
    t_drop();
    t_clear();
    t_pointer();
    t_trunc();
    t_no_pong();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule